// File: doc/BRIEF.md
# Depth-Cascade Result Arbiter

A chain of search devices shares one external associated-data memory bus, and only one of them may drive it at a time. This arbiter looks at what every device in the chain reports for the current operation and picks that one device. For a search, the owner is the most upstream device with a match. If nothing matches, the last device in the chain takes the bus. For a read or a write, the owner is the device whose identifier equals the target. If the target is the global identifier, the last device owns the bus. For a write to the next free slot, the owner is the most upstream device that still has room.

The result is registered one clock after the operation is presented. It is made up of a one-hot drive-enable vector, the winner's identifier, and the memory address. That address is the identifier placed above a local address. The arbiter also forms the cascaded full chain, which it puts out as two identical copies for each position, and it forms a registered table-full flag.

Top module: `cascade_arbiter`

## Requirements
- R1: While reset is asserted and after its release, before any operation is accepted, `res_valid`, `drv_en`, `res_id`, `res_addr`, `res_hit`, `res_multi` and `table_full` are all zero.
- R2: For a search (`op_kind` = 2'b10) where at least one `dev_hit` bit is set, the lowest-indexed hitting device wins. On the next clock `drv_en` has only that bit set, `res_id` is that device's identifier, `res_addr` is {identifier, that device's `dev_addr` lane} and `res_hit` = 1.
- R3: For a search with no hits, the last device (index N_DEV-1) wins. `res_hit` = 0 and `res_addr` is {last identifier, last lane}.
- R4: `res_multi` is 1 exactly when the registered operation was a search with two or more hits. It is 0 otherwise.
- R5: For a read (2'b00) or a write (2'b01) with `op_target` = 5'h1F (the global identifier), the last device wins. `res_addr` = {last identifier, `op_addr`} and `res_hit` = 1.
- R6: For a read or a write with any other target, the device whose identifier equals `op_target` wins, with `res_addr` = {identifier, `op_addr`} and `res_hit` = 1. If no identifier matches, the last device wins with `res_hit` = 0. Identifiers are unique and never 5'h1F.
- R7: For a next-free write (2'b11), the lowest-indexed device with `dev_full` = 0 wins, with `res_addr` = {identifier, its lane} and `res_hit` = 1. If every device is full, the last device wins with `res_hit` = 0.
- R8: `res_valid` follows `op_valid` by one clock. When it is 1, exactly one `drv_en` bit is set. When it is 0, `drv_en`, `res_hit` and `res_multi` are 0, and `res_id` and `res_addr` keep their previous values.
- R9: `full_out_a[i]` and `full_out_b[i]` are combinational and equal. Each is 1 exactly when `dev_full[0]` through `dev_full[i]` are all 1.
- R10: `table_full` is 1 on the clock after all `dev_full` bits are 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 00 read, 01 write, 10 search, 11 next-free write |
| op_target | input | 5 | Target identifier for a read or a write; 5'h1F is global |
| op_addr | input | ADDR_W | Local address for a read or a write |
| dev_id | input | 5*N_DEV | Identifier of each device, with device i at bits [5i+4:5i] |
| dev_hit | input | N_DEV | Local match of each device |
| dev_addr | input | ADDR_W*N_DEV | Local match address (search) or next free address (next-free write) for each device |
| dev_full | input | N_DEV | Own full state of each device |
| full_out_a | output | N_DEV | Cascaded full for each position, first copy |
| full_out_b | output | N_DEV | Cascaded full for each position, second copy |
| table_full | output | 1 | Registered whole-chain full |
| res_valid | output | 1 | Result valid |
| drv_en | output | N_DEV | One-hot bus drive enable |
| res_id | output | 5 | Winning identifier |
| res_addr | output | 5+ADDR_W | {winning identifier, local address} |
| res_hit | output | 1 | Search matched, target found, or free slot found |
| res_multi | output | 1 | Search with two or more matches |

## Verification
The assertions assume that the identifiers on `dev_id` are unique and that none of them equals the global value 5'h1F. The assertion that a winner never reports the global identifier depends on this. The bench gives device i the identifier (7i+3) mod 31. That mapping is distinct for every index below 31 and never reaches 31, so the assumption holds throughout. Targets, hit masks and full masks are otherwise unconstrained. Random targets include unassigned and global values, and the full masks include contiguous prefixes, so both the fallback paths and the chain boundaries are reached.

// File: rtl/cascade_arbiter.sv
module cascade_arbiter #(
  parameter int N_DEV  = 8,
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [1:0]                op_kind,
  input  logic [4:0]                op_target,
  input  logic [ADDR_W-1:0]         op_addr,
  input  logic [N_DEV*5-1:0]        dev_id,
  input  logic [N_DEV-1:0]          dev_hit,
  input  logic [N_DEV*ADDR_W-1:0]   dev_addr,
  input  logic [N_DEV-1:0]          dev_full,
  output logic [N_DEV-1:0]          full_out_a,
  output logic [N_DEV-1:0]          full_out_b,
  output logic                      table_full,
  output logic                      res_valid,
  output logic [N_DEV-1:0]          drv_en,
  output logic [4:0]                res_id,
  output logic [5+ADDR_W-1:0]       res_addr,
  output logic                      res_hit,
  output logic                      res_multi
);

  localparam int              IDX_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(N_DEV - 1);
  localparam logic [4:0]      GLOBAL_ID = 5'h1F;
  localparam logic [1:0]      K_SEARCH  = 2'b10;
  localparam logic [1:0]      K_NFREE   = 2'b11;

  logic [N_DEV-1:0] chain;

  for (genvar g = 0; g < N_DEV; g++) begin : g_chain
    assign chain[g] = &dev_full[g:0];
  end

  assign full_out_a = chain;
  assign full_out_b = chain;

  logic [IDX_W-1:0] hit_idx, free_idx, tgt_idx, pick;
  logic             any_hit, any_free, tgt_ok, pick_ok;

  always_comb begin
    hit_idx  = LAST;
    free_idx = LAST;
    tgt_idx  = LAST;
    any_hit  = 1'b0;
    any_free = 1'b0;
    tgt_ok   = 1'b0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (dev_hit[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
      if (!dev_full[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (dev_id[i*5 +: 5] == op_target) begin
        tgt_idx = IDX_W'(i);
        tgt_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    case (op_kind)
      K_SEARCH: begin pick = hit_idx;  pick_ok = any_hit;  end
      K_NFREE:  begin pick = free_idx; pick_ok = any_free; end
      default: begin
        if (op_target == GLOBAL_ID) begin
          pick    = LAST;
          pick_ok = 1'b1;
        end else begin
          pick    = tgt_idx;
          pick_ok = tgt_ok;
        end
      end
    endcase
  end

  logic [4:0]        pick_id;
  logic [ADDR_W-1:0] lane, lo_addr;
  logic              multi;

  assign pick_id = dev_id[pick*5 +: 5];
  assign lane    = dev_addr[pick*ADDR_W +: ADDR_W];
  assign lo_addr = op_kind[1] ? lane : op_addr;
  assign multi   = (op_kind == K_SEARCH) && ($countones(dev_hit) > 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      table_full <= 1'b0;
      drv_en     <= '0;
      res_id     <= '0;
      res_addr   <= '0;
      res_hit    <= 1'b0;
      res_multi  <= 1'b0;
    end else begin
      res_valid  <= op_valid;
      table_full <= chain[N_DEV-1];
      if (op_valid) begin
        drv_en    <= N_DEV'(1) << pick;
        res_id    <= pick_id;
        res_addr  <= {pick_id, lo_addr};
        res_hit   <= pick_ok;
        res_multi <= multi;
      end else begin
        drv_en    <= '0;
        res_hit   <= 1'b0;
        res_multi <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cascade_arbiter_chk.sv
module cascade_arbiter_chk #(
  parameter int N_DEV  = 8,
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic [1:0]          op_kind,
  input logic [N_DEV-1:0]    dev_full,
  input logic [N_DEV-1:0]    full_out_a,
  input logic                table_full,
  input logic                res_valid,
  input logic [N_DEV-1:0]    drv_en,
  input logic [4:0]          res_id,
  input logic                res_hit,
  input logic                res_multi
);

  AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(drv_en) == 1); // R8

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> drv_en == '0); // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R8

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi |-> res_hit); // R4

  AST_MISS_GOES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && $past(op_kind) == 2'b10) |-> drv_en[N_DEV-1]); // R3

  AST_NO_GLOBAL_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_id != 5'h1F); // R6

  AST_TABLE_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    full_out_a[N_DEV-1] |=> table_full); // R10

  AST_TABLE_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !full_out_a[N_DEV-1] |=> !table_full); // R10

  for (genvar g = 1; g < N_DEV; g++) begin : g_mono
    AST_CHAIN_UPSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
      full_out_a[g] |-> (full_out_a[g-1] && dev_full[g])); // R9
  end

endmodule

bind cascade_arbiter cascade_arbiter_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .dev_full(dev_full), .full_out_a(full_out_a), .table_full(table_full),
  .res_valid(res_valid), .drv_en(drv_en), .res_id(res_id),
  .res_hit(res_hit), .res_multi(res_multi)
);

// File: tb/cascade_arbiter_tb.sv
`timescale 1ns/1ps
module cascade_arbiter_tb;
  localparam int N  = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            op_valid;
  logic [1:0]      op_kind;
  logic [4:0]      op_target;
  logic [AW-1:0]   op_addr;
  logic [N*5-1:0]  dev_id;
  logic [N-1:0]    dev_hit;
  logic [N*AW-1:0] dev_addr;
  logic [N-1:0]    dev_full;
  logic [N-1:0]    full_out_a, full_out_b, drv_en;
  logic            table_full, res_valid, res_hit, res_multi;
  logic [4:0]      res_id;
  logic [5+AW-1:0] res_addr;

  logic [4:0]    ids   [N];
  logic [AW-1:0] lanes [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      dev_id[i*5 +: 5]    = ids[i];
      dev_addr[i*AW +: AW] = lanes[i];
    end
  end

  cascade_arbiter #(.N_DEV(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_target(op_target), .op_addr(op_addr), .dev_id(dev_id),
    .dev_hit(dev_hit), .dev_addr(dev_addr), .dev_full(dev_full),
    .full_out_a(full_out_a), .full_out_b(full_out_b), .table_full(table_full),
    .res_valid(res_valid), .drv_en(drv_en), .res_id(res_id),
    .res_addr(res_addr), .res_hit(res_hit), .res_multi(res_multi)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic            e_valid, e_hit, e_multi, e_tf;
  logic [N-1:0]    e_drv;
  logic [4:0]      e_id;
  logic [5+AW-1:0] e_addr;
  string           e_tag;

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag_win);
    cmp("R8", "res_valid", 32'(res_valid), 32'(e_valid));
    cmp(tag_win, "drv_en", 32'(drv_en), 32'(e_drv));
    cmp(tag_win, "res_id", 32'(res_id), 32'(e_id));
    cmp(tag_win, "res_addr", 32'(res_addr), 32'(e_addr));
    cmp(tag_win, "res_hit", 32'(res_hit), 32'(e_hit));
    cmp("R4", "res_multi", 32'(res_multi), 32'(e_multi));
    cmp("R10", "table_full", 32'(table_full), 32'(e_tf));
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [4:0] tgt,
                      input logic [AW-1:0] a, input logic [N-1:0] hit,
                      input logic [N-1:0] full);
    int win;
    int nh;
    bit ok;
    op_valid  = v;
    op_kind   = k;
    op_target = tgt;
    op_addr   = a;
    dev_hit   = hit;
    dev_full  = full;
    for (int i = 0; i < N; i++) lanes[i] = AW'($urandom);
    #1;
    for (int i = 0; i < N; i++) begin
      bit pre = 1'b1;
      for (int j = 0; j <= i; j++) pre = pre & full[j];
      cmp("R9", "full_out_a", 32'(full_out_a[i]), 32'(pre));
      cmp("R9", "full_out_b", 32'(full_out_b[i]), 32'(pre));
    end
    win = -1;
    ok  = 1'b0;
    nh  = 0;
    for (int i = 0; i < N; i++) if (hit[i]) nh++;
    if (k == 2'b10) begin
      for (int i = 0; i < N; i++) if (win < 0 && hit[i]) win = i;
      e_tag = (win < 0) ? "R3" : "R2";
    end else if (k == 2'b11) begin
      for (int i = 0; i < N; i++) if (win < 0 && !full[i]) win = i;
      e_tag = "R7";
    end else if (tgt == 5'h1F) begin
      win = N - 1;
      e_tag = "R5";
    end else begin
      for (int i = 0; i < N; i++) if (win < 0 && ids[i] == tgt) win = i;
      e_tag = "R6";
    end
    ok = (win >= 0);
    if (win < 0) win = N - 1;
    e_tf = &full;
    if (v) begin
      e_valid = 1'b1;
      e_drv   = N'(1) << win;
      e_id    = ids[win];
      e_addr  = {ids[win], (k[1] ? lanes[win] : a)};
      e_hit   = ok;
      e_multi = (k == 2'b10) && (nh >= 2);
    end else begin
      e_valid = 1'b0;
      e_drv   = '0;
      e_hit   = 1'b0;
      e_multi = 1'b0;
      e_tag   = "R8";
    end
    @(negedge clk);
    check_regs(e_tag);
  endtask

  initial begin
    #(4.0 * 200000);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      ids[i]   = 5'((i * 7 + 3) % 31);
      lanes[i] = '0;
    end
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'b00; op_target = '0;
    op_addr = '0; dev_hit = '0; dev_full = '0;
    e_valid = 0; e_drv = '0; e_id = '0; e_addr = '0; e_hit = 0; e_multi = 0; e_tf = 0;
    repeat (3) @(negedge clk);
    check_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    step(1, 2'b10, 5'd0, 12'h000, 8'b0000_0100, 8'h00);
    step(1, 2'b10, 5'd0, 12'h000, 8'b1000_0000, 8'h00);
    step(1, 2'b10, 5'd0, 12'h000, 8'b0000_0001, 8'h00);
    step(1, 2'b10, 5'd0, 12'h000, 8'b0110_1000, 8'h00);
    step(1, 2'b10, 5'd0, 12'h000, 8'b0000_0000, 8'h00);
    step(0, 2'b10, 5'd0, 12'h000, 8'b1111_1111, 8'h00);
    step(1, 2'b00, 5'h1F, 12'hABC, 8'h00, 8'h00);
    step(1, 2'b01, 5'h1F, 12'h123, 8'hFF, 8'h0F);
    step(1, 2'b00, ids[2], 12'h456, 8'h00, 8'h00);
    step(1, 2'b01, ids[7], 12'h789, 8'h01, 8'h00);
    step(1, 2'b00, 5'd5, 12'h321, 8'h00, 8'h00);
    step(1, 2'b11, 5'd0, 12'h000, 8'h00, 8'b0000_0111);
    step(1, 2'b11, 5'd0, 12'h000, 8'h00, 8'hFF);
    step(1, 2'b11, 5'd0, 12'h000, 8'h00, 8'b1111_1101);
    step(0, 2'b00, 5'd0, 12'h000, 8'h00, 8'hFF);

    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] h, f;
      logic [4:0]   t;
      case ($urandom % 4)
        0: h = '0;
        1: h = N'($urandom) & N'($urandom) & N'($urandom);
        2: h = N'(1) << ($urandom % N);
        default: h = N'($urandom);
      endcase
      case ($urandom % 3)
        0: f = N'((1 << ($urandom % (N + 1))) - 1);
        1: f = N'($urandom) | N'($urandom);
        default: f = N'($urandom);
      endcase
      case ($urandom % 3)
        0: t = 5'h1F;
        1: t = ids[$urandom % N];
        default: t = 5'($urandom);
      endcase
      step(($urandom % 5) != 0, 2'($urandom), t, AW'($urandom), h, f);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule